// File: doc/BRIEF.md
# Linear Ratio Video Downscaler

This block shrinks a stream of 8-bit luma samples by a programmable linear ratio in each direction. The ratio is N/96. Separate registers give the horizontal numerator and the vertical numerator. Each direction uses a phase accumulator. The accumulator adds the numerator on every input sample, or on every input line. When the sum reaches 96 or more, 96 is taken off and that sample or line is kept. The kept samples leave as a valid-qualified stream. A line-keep level and a line-start pulse tell a frame-store writer which input lines survive.

A numerator of zero turns the picture off. Numerators above the legal maximum are treated as the maximum: 48 horizontally (half size) and 96 vertically (full height). The block also has a read-side expander for the display stream. It tells the frame-store reader when to move to a new stored pixel and when to move to a new stored line. This repeats each pixel once, twice or four times, and each line once or twice.

Top module: `lin_downscaler`

## Requirements
- R1: With a horizontal numerator H (0..48), a line of L input samples yields exactly floor(L*H/96) output samples. For L=1408, H=48 gives 704 and H=24 gives 352.
- R2: Input sample k of a line (k counted from 0 at the line start) is output when floor((k+1)*H/96) > floor(k*H/96). The output appears with out_vld one clock after that sample is accepted, and out_y carries that sample's value.
- R3: A horizontal or vertical numerator of zero produces no output samples.
- R4: A horizontal numerator above 48 behaves as 48. A vertical numerator above 96 behaves as 96.
- R5: With a vertical numerator V, a field of M input lines keeps floor(M*V/96) lines. For M=228 and V=48 this is 114 lines. Line j is kept when floor((j+1)*V/96) > floor(j*V/96). Output samples occur only inside kept lines.
- R6: The horizontal accumulator restarts at every line start, and the vertical accumulator restarts at every field start. Decimation patterns therefore do not depend on what came before.
- R7: For a kept line, out_lstart pulses for one clock, one clock after the line start. out_lkeep is high from that clock until the next line start, and low for dropped lines.
- R8: The pixel expansion code on hexp_i repeats each stored pixel: 00 = x1, 01 = x2, 11 = x4, 10 = x1. rd_px_adv is high, one clock after a display cycle, for the first display cycle of each repeat group. The repeat count restarts at disp_line.
- R9: With vdbl_i=0, rd_ln_adv pulses one clock after every display line start. With vdbl_i=1, it pulses on every second display line start, counting from the display field start.
- R10: Each phase accumulator always stays below 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hred_i | input | 6 | Horizontal numerator (ratio hred_i/96) |
| vred_i | input | 7 | Vertical numerator (ratio vred_i/96) |
| hexp_i | input | 2 | Read-side pixel repeat code |
| vdbl_i | input | 1 | Read-side line doubling |
| in_vld | input | 1 | Input sample valid |
| in_line | input | 1 | First sample of a line (with in_vld) |
| in_field | input | 1 | First line of a field (with in_line) |
| in_y | input | 8 | Input luma sample |
| out_vld | output | 1 | Output sample valid |
| out_y | output | 8 | Output luma sample |
| out_lkeep | output | 1 | Current input line is kept |
| out_lstart | output | 1 | Pulse at the start of a kept line |
| disp_vld | input | 1 | Display pixel cycle |
| disp_line | input | 1 | First display cycle of a line |
| disp_field | input | 1 | First display line of a field |
| rd_px_adv | output | 1 | Reader moves to a new stored pixel |
| rd_ln_adv | output | 1 | Reader moves to a new stored line |

## Verification
The horizontal path is driven with full 1408-sample lines at ratios 48 and 24. It is also driven with short lines at ratio 36, whose irregular keep pattern separates a correct accumulator from one that only divides by a fixed step. The vertical path is driven with full 228-line fields at ratios 96, 48, 24 and 72. Here the kept-line counts show whether rounding and carry-over between lines are right. Further runs use out-of-range and zero numerators to show clamping and the off state apart. The two restart checks follow a partial line or a short field, so an accumulator that is not cleared leaves a visible phase offset. Each expansion code and the line-doubling bit are tried on short display lines, and the counted advances identify the repeat factor.

// File: rtl/lds_pkg.sv
package lds_pkg;
    localparam int PIX_W     = 8;
    localparam int RATIO_DEN = 96;
    localparam int HRED_W    = 6;
    localparam int VRED_W    = 7;
    localparam int HRED_MAX  = 48;
    localparam int VRED_MAX  = 96;

    typedef enum logic [1:0] {
        EXP_X1  = 2'b00,
        EXP_X2  = 2'b01,
        EXP_RSV = 2'b10,
        EXP_X4  = 2'b11
    } exp_code_e;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] y;
    } pix_t;

    // index of the last display cycle in a repeat group
    function automatic logic [1:0] rep_last(input logic [1:0] code);
        case (exp_code_e'(code))
            EXP_X2:  return 2'd1;
            EXP_X4:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/lds_phase_acc.sv
module lds_phase_acc #(
    parameter int RW  = 6,
    parameter int DEN = 96,
    parameter int MAX = 48
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          restart,
    input  logic [RW-1:0] ratio,
    output logic          hit
);
    localparam int AW = $clog2(DEN + MAX + 1);

    logic [AW-1:0] acc_q;
    logic [AW-1:0] rat_c;
    logic [AW-1:0] base;
    logic [AW-1:0] sum;
    logic          over;

    always_comb begin
        rat_c = (ratio > RW'(MAX)) ? AW'(MAX) : AW'(ratio);
        base  = restart ? '0 : acc_q;
        sum   = base + rat_c;
        over  = (sum >= AW'(DEN));
        hit   = step && over;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= over ? (sum - AW'(DEN)) : sum;
        end
    end

    // R10: phase never reaches the denominator
    p_acc_below_den_r10: assert property (@(posedge clk) disable iff (rst)
        acc_q < AW'(DEN));
    // R3: no step means no hit
    p_hit_needs_step_r3: assert property (@(posedge clk) disable iff (rst)
        !step |-> !hit);
endmodule

// File: rtl/lds_expander.sv
module lds_expander (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] hexp_i,
    input  logic       vdbl_i,
    input  logic       disp_vld,
    input  logic       disp_line,
    input  logic       disp_field,
    output logic       rd_px_adv,
    output logic       rd_ln_adv
);
    import lds_pkg::*;

    logic [1:0] pcnt_q, pbase, plast;
    logic       lph_q, lbase;

    always_comb begin
        plast = rep_last(hexp_i);
        pbase = disp_line ? 2'd0 : pcnt_q;
        lbase = disp_field ? 1'b0 : lph_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q    <= '0;
            lph_q     <= 1'b0;
            rd_px_adv <= 1'b0;
            rd_ln_adv <= 1'b0;
        end else begin
            rd_px_adv <= disp_vld && (pbase == 2'd0);
            rd_ln_adv <= disp_line && (!vdbl_i || !lbase);
            if (disp_vld) begin
                pcnt_q <= (pbase >= plast) ? 2'd0 : pbase + 2'd1;
            end
            if (disp_line) begin
                lph_q <= vdbl_i ? ~lbase : 1'b0;
            end
        end
    end

    // R8: single repeat advances on every display cycle
    p_x1_every_r8: assert property (@(posedge clk) disable iff (rst)
        $past(disp_vld && hexp_i == 2'b00) |-> rd_px_adv);
    p_px_needs_vld_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!disp_vld) |-> !rd_px_adv);
    // R9: no doubling means every line advances
    p_line_plain_r9: assert property (@(posedge clk) disable iff (rst)
        $past(disp_line && !vdbl_i) |-> rd_ln_adv);
endmodule

// File: rtl/lin_downscaler.sv
module lin_downscaler
    import lds_pkg::*;
#(
    parameter int PW  = PIX_W,
    parameter int HW  = HRED_W,
    parameter int VW  = VRED_W,
    parameter int DEN = RATIO_DEN,
    parameter int HMX = HRED_MAX,
    parameter int VMX = VRED_MAX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] hred_i,
    input  logic [VW-1:0] vred_i,
    input  logic [1:0]    hexp_i,
    input  logic          vdbl_i,
    input  logic          in_vld,
    input  logic          in_line,
    input  logic          in_field,
    input  logic [PW-1:0] in_y,
    output logic          out_vld,
    output logic [PW-1:0] out_y,
    output logic          out_lkeep,
    output logic          out_lstart,
    input  logic          disp_vld,
    input  logic          disp_line,
    input  logic          disp_field,
    output logic          rd_px_adv,
    output logic          rd_ln_adv
);
    logic h_hit, v_hit, keep_now, lkeep_q, lstart_q;
    pix_t pix_q;

    lds_phase_acc #(.RW(HW), .DEN(DEN), .MAX(HMX)) u_hacc (
        .clk(clk), .rst(rst), .step(in_vld), .restart(in_line),
        .ratio(hred_i), .hit(h_hit)
    );

    lds_phase_acc #(.RW(VW), .DEN(DEN), .MAX(VMX)) u_vacc (
        .clk(clk), .rst(rst), .step(in_vld && in_line), .restart(in_field),
        .ratio(vred_i), .hit(v_hit)
    );

    always_comb keep_now = (in_vld && in_line) ? v_hit : lkeep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q    <= '0;
            lkeep_q  <= 1'b0;
            lstart_q <= 1'b0;
        end else begin
            pix_q.vld <= h_hit && keep_now;
            if (h_hit) pix_q.y <= in_y;
            if (in_vld && in_line) lkeep_q <= v_hit;
            lstart_q <= in_vld && in_line && v_hit;
        end
    end

    assign out_vld    = pix_q.vld;
    assign out_y      = pix_q.y;
    assign out_lkeep  = lkeep_q;
    assign out_lstart = lstart_q;

    lds_expander u_exp (
        .clk(clk), .rst(rst), .hexp_i(hexp_i), .vdbl_i(vdbl_i),
        .disp_vld(disp_vld), .disp_line(disp_line), .disp_field(disp_field),
        .rd_px_adv(rd_px_adv), .rd_ln_adv(rd_ln_adv)
    );

    // R1: at most half rate, so never two outputs in a row
    p_no_back_to_back_r1: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);
    // R3: zero horizontal numerator silences the output
    p_zero_h_off_r3: assert property (@(posedge clk) disable iff (rst)
        $past(hred_i == '0) |-> !out_vld);
    // R5: samples only inside kept lines
    p_vld_in_kept_r5: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> out_lkeep);
    // R7: line-start pulse marks a kept line
    p_lstart_kept_r7: assert property (@(posedge clk) disable iff (rst)
        out_lstart |-> out_lkeep);
endmodule

// File: tb/sim_lin_downscaler.sv
module sim_lin_downscaler;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] hred_i = '0;
    logic [6:0] vred_i = '0;
    logic [1:0] hexp_i = '0;
    logic       vdbl_i = 1'b0;
    logic       in_vld = 1'b0, in_line = 1'b0, in_field = 1'b0;
    logic [7:0] in_y = '0;
    logic       out_vld, out_lkeep, out_lstart;
    logic [7:0] out_y;
    logic       disp_vld = 1'b0, disp_line = 1'b0, disp_field = 1'b0;
    logic       rd_px_adv, rd_ln_adv;

    always #10 clk = ~clk;

    lin_downscaler u0 (
        .clk(clk), .rst(rst), .hred_i(hred_i), .vred_i(vred_i),
        .hexp_i(hexp_i), .vdbl_i(vdbl_i), .in_vld(in_vld), .in_line(in_line),
        .in_field(in_field), .in_y(in_y), .out_vld(out_vld), .out_y(out_y),
        .out_lkeep(out_lkeep), .out_lstart(out_lstart), .disp_vld(disp_vld),
        .disp_line(disp_line), .disp_field(disp_field),
        .rd_px_adv(rd_px_adv), .rd_ln_adv(rd_ln_adv)
    );

    int total = 0, fails = 0;
    int nsmp = 0, nls = 0, npx = 0, nln = 0, ncap = 0;
    logic [7:0] cap [64];
    bit done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_vld) begin
                nsmp++;
                if (ncap < 64) begin cap[ncap] = out_y; ncap++; end
            end
            if (out_lstart) nls++;
            if (rd_px_adv) npx++;
            if (rd_ln_adv) nln++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0; in_line = 1'b0; in_field = 1'b0;
            disp_vld = 1'b0; disp_line = 1'b0; disp_field = 1'b0;
        end
    endtask

    task automatic run_line(input int len, input bit fs);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_vld = 1'b1; in_line = (i == 0); in_field = fs && (i == 0);
            in_y = 8'(i);
        end
        idle(2);
    endtask

    task automatic run_disp(input int nlines, input int len);
        for (int l = 0; l < nlines; l++) begin
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                disp_vld = 1'b1; disp_line = (i == 0);
                disp_field = (l == 0) && (i == 0);
            end
            idle(1);
        end
        idle(1);
    endtask

    // hred, vred, line length, lines, expected samples, expected kept lines
    localparam int NV = 9;
    localparam int TAB [NV][6] = '{
        '{48,  96, 1408,   1, 704,   1},  // R1
        '{24,  96, 1408,   1, 352,   1},  // R1
        '{63,  96,  100,   1,  50,   1},  // R4
        '{ 0,  96,  100,   1,   0,   1},  // R3
        '{48,   0,    8,  10,   0,   0},  // R3
        '{48,  48,    4, 228, 228, 114},  // R5
        '{48, 127,    4, 228, 456, 228},  // R4
        '{12,  24,   96, 228, 684,  57},  // R5
        '{36,  72,   16, 228, 1026, 171}  // R5
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!out_vld && !out_lkeep && !out_lstart && !rd_px_adv && !rd_ln_adv,
            "reset", int'(out_vld) + int'(out_lkeep) + int'(rd_px_adv), 0);

        // table walk: R1 R3 R4 R5
        for (int t = 0; t < NV; t++) begin
            @(negedge clk);
            hred_i = 6'(TAB[t][0]); vred_i = 7'(TAB[t][1]);
            nsmp = 0; nls = 0;
            for (int l = 0; l < TAB[t][3]; l++) run_line(TAB[t][2], l == 0);
            chk(nsmp == TAB[t][4], "R1/R3/R4 sample count", nsmp, TAB[t][4]);
            chk(nls == TAB[t][5], "R5 kept lines", nls, TAB[t][5]);
        end

        // R2 + R6: partial line leaves phase, next line must restart
        hred_i = 6'd36; vred_i = 7'd96;
        run_line(4, 1'b1);
        ncap = 0;
        run_line(16, 1'b0);
        begin
            int n = 0;
            for (int k = 0; k < 16; k++) begin
                if (((k + 1) * 36) / 96 > (k * 36) / 96) begin
                    if (n < ncap)
                        chk(cap[n] == 8'(k), "R2/R6 sample position", int'(cap[n]), k);
                    n++;
                end
            end
            chk(ncap == n, "R2 output count", ncap, n);
        end

        // R7 + R2 timing
        hred_i = 6'd48; vred_i = 7'd96;
        @(negedge clk);
        in_vld = 1'b1; in_line = 1'b1; in_field = 1'b1; in_y = 8'd5;
        @(negedge clk);
        chk(out_lstart && out_lkeep && !out_vld, "R7 line start pulse",
            int'(out_lstart), 1);
        in_line = 1'b0; in_field = 1'b0; in_y = 8'd9;
        @(negedge clk);
        chk(!out_lstart && out_lkeep, "R7 pulse width / keep level",
            int'(out_lstart), 0);
        chk(out_vld && out_y == 8'd9, "R2 one-cycle latency", int'(out_y), 9);
        idle(2);

        // R6 vertical: short field leaves phase 48, new field must restart
        vred_i = 7'd48;
        run_line(2, 1'b1);
        @(negedge clk);
        in_vld = 1'b1; in_line = 1'b1; in_field = 1'b1; in_y = 8'd1;
        @(negedge clk);
        chk(!out_lkeep, "R6 field restart", int'(out_lkeep), 0);
        idle(2);

        // R5 drop: line 0 of V=48 field is dropped
        @(negedge clk);
        chk(!out_lkeep && !out_vld, "R5 dropped line", int'(out_lkeep), 0);

        // R8 repeat codes
        for (int c = 0; c < 4; c++) begin
            int expx;
            expx = (c == 1) ? 4 : (c == 3) ? 2 : 8;
            @(negedge clk);
            hexp_i = 2'(c);
            npx = 0;
            run_disp(1, 8);
            chk(npx == expx, "R8 pixel repeat", npx, expx);
        end

        // R9 line doubling
        hexp_i = 2'b00;
        vdbl_i = 1'b0; nln = 0;
        run_disp(4, 2);
        chk(nln == 4, "R9 no doubling", nln, 4);
        vdbl_i = 1'b1; nln = 0;
        run_disp(4, 2);
        chk(nln == 2, "R9 doubling", nln, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule